// File: doc/BRIEF.md
# Serial Audio Sample Receiver

This block turns a three-wire serial audio stream (a bit clock, a word clock and one data line) into parallel signed samples for the left and right channels. All three wires are sampled by a faster system clock through a synchronizer, and the block finds the bit clock's rising edges in that clock domain. A data bit is taken on each rising edge of the bit clock. The word clock runs at the sample rate and marks which channel the current bits belong to, so each word clock period yields one left sample and one right sample.

The bits can be framed in two ways. In right-justified framing the last bit of a word comes just before the word clock changes. In I2S framing the first bit of a word comes one bit clock after the word clock changes. Three static inputs, driven by a control register block, set the framing, the word length (16, 20 or 24 bits) and which word clock level means left. Each sample is sign-extended to 24 bits and presented for one system clock, together with a tag that names its channel. Any bit clock slots in a half-frame beyond the word length are ignored. When a control input changes, the frame in progress is dropped and the receiver waits for new word clock edges before it delivers anything.

Top module: `serial_audio_rx`

## Requirements
- R1: Bit clock, word clock and data each pass through a two-stage synchronizer. A data bit is taken at each rising bit clock edge seen in the system clock domain. A sample is delivered exactly 3 system clock edges after the bit clock rise that completes it.
- R2: The word length input `wordSel` selects N: 2'b00 gives 16 bits, 2'b01 gives 20 bits, 2'b10 gives 24 bits. The reserved code 2'b11 is handled as 24 bits.
- R3: Right-justified framing: the sample is the last N bits received before a word clock transition, MSB first. It is delivered on the first bit clock rise that sees the new word clock level. Leading extra bits in the half-frame do not affect the value.
- R4: I2S framing: the MSB is the bit at the second bit clock rise after the word clock transition, and the next N-1 rises carry the remaining bits. The sample is delivered on the rise that carries its LSB. Trailing extra bits do not affect the value.
- R5: With `lrPolarity`=0, a high word clock means left and a low word clock means right. With `lrPolarity`=1 the two are swapped. `sampleRight` is 0 for a left sample and 1 for a right sample.
- R6: `sampleData` is the N-bit word in two's complement, sign-extended to 24 bits.
- R7: `fmtI2s`=0 selects right-justified framing and `fmtI2s`=1 selects I2S framing.
- R8: `sampleValid` is high for exactly one system clock per sample. Each full word clock period delivers one left sample and one right sample.
- R9: When any control input changes, the partial frame is dropped and no sample is delivered in the next cycle. Delivery resumes only after a word clock transition has been seen under the new settings. In right-justified framing this means only after a full half-frame that lies between two such transitions.
- R10: After reset, `sampleValid`, `sampleData` and `sampleRight` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock; data is taken on its rising edge |
| wordClk | input | 1 | Word clock at the sample rate; its level selects the channel |
| serData | input | 1 | Serial data, MSB first |
| fmtI2s | input | 1 | Framing: 0 right-justified, 1 I2S |
| wordSel | input | 2 | Word length: 00=16, 01=20, 10=24, 11=24 |
| lrPolarity | input | 1 | 0: high word clock is left; 1: high word clock is right |
| sampleData | output | 24 | Sign-extended received sample |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |
| sampleRight | output | 1 | Channel tag: 0 left, 1 right |

## Verification
Two register stages of synchronizer, one edge-detect compare and one output register lie between a bit clock rise on the pin and the output. Every sample is therefore due 3 system clock edges after the rise that completes it. That rise is the first rise of the next half-frame in right-justified framing, and the rise carrying the LSB in I2S framing. The bench drives the pins only on falling system clock edges, stamps the cycle of each bit clock rise it produces, and checks every strobe at a falling edge against that stamp. The same check compares the value and channel against an ordered list of expected samples built from the requirements. At the end of each run the bench also checks that the list has been emptied, and it checks that no strobe arrives when nothing is expected, so that dropped samples and extra samples both count as failures.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  // Common output sample width; all word lengths are sign-extended to it.
  localparam int SAMPLE_W = 24;
  localparam int LEN_SHORT = 16;
  localparam int LEN_MID   = 20;
  localparam int LEN_LONG  = 24;

  // Word length select codes.
  typedef enum logic [1:0] {
    WL_16  = 2'b00,
    WL_20  = 2'b01,
    WL_24  = 2'b10,
    WL_RSV = 2'b11
  } wordLen_e;

  // Strobes from the control path to the datapath, valid for one cycle.
  typedef struct packed {
    logic shiftEn;   // a new serial bit is present this cycle
    logic capture;   // a complete word is ready to be presented
    logic useNew;    // the word includes the bit arriving this cycle
    logic isRight;   // channel tag of the captured word
  } rxStrobe_t;

  // Number of bits per word for a select code (reserved decodes as the longest).
  function automatic int unsigned wordBits(input logic [1:0] sel);
    case (sel)
      WL_16:   return LEN_SHORT;
      WL_20:   return LEN_MID;
      default: return LEN_LONG;
    endcase
  endfunction

endpackage

// File: rtl/sarx_edge_sync.sv
module sarx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitClk,
  input  logic wordClk,
  input  logic serData,
  output logic bckRise,
  output logic wsLevel,
  output logic dataBit
);

  localparam int LANES = 3;

  logic [LANES-1:0] pinNow;
  logic [LANES-1:0] syncOut;
  logic             bckLast;

  assign pinNow = {serData, wordClk, bitClk};

  // One synchronizer chain per serial wire; all three share the same depth
  // so that data and word clock stay aligned with the bit clock.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [STAGES-1:0] chainQ;
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= pinNow[lane];
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chainQ <= '0;
        else       chainQ <= {chainQ[STAGES-2:0], pinNow[lane]};
      end
    end
    assign syncOut[lane] = chainQ[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) bckLast <= 1'b0;
    else       bckLast <= syncOut[0];
  end

  assign bckRise = syncOut[0] & ~bckLast;
  assign wsLevel = syncOut[1];
  assign dataBit = syncOut[2];

  // A rising edge seen through the chain can never last two cycles.
  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    bckRise |=> !bckRise); // R1

endmodule

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
#(
  parameter int CNT_W = $clog2(SAMPLE_W) + 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bckRise,
  input  logic       wsLevel,
  input  logic       fmtI2s,
  input  logic [1:0] wordSel,
  input  logic       lrPolarity,
  output rxStrobe_t  strobe
);

  localparam int CFG_W = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CFG_W-1:0] cfgNow;
  logic [CFG_W-1:0] cfgPrev;
  logic             cfgChanged;
  logic             primed;
  logic             locked;
  logic             wsLast;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nBits;
  logic             wordEdge;
  logic             rjTake;
  logic             i2sTake;

  assign cfgNow     = {fmtI2s, lrPolarity, wordSel};
  assign cfgChanged = (cfgNow != cfgPrev);
  assign nBits      = CNT_W'(wordBits(wordSel));

  // A word clock transition is only trusted once a previous level exists.
  assign wordEdge = bckRise && primed && (wsLevel != wsLast);

  // Right-justified: the word ends at the transition; enough bits must have
  // arrived in the half-frame that just closed.
  assign rjTake  = !fmtI2s && wordEdge && locked && (bitCnt >= nBits);

  // I2S: one delay slot after the transition, then N bits; the Nth one
  // completes the word on the rise where the old count equals N.
  assign i2sTake = fmtI2s && bckRise && !wordEdge && locked && (bitCnt == nBits);

  always_comb begin
    strobe.shiftEn = bckRise && !cfgChanged;
    strobe.capture = (rjTake || i2sTake) && !cfgChanged;
    strobe.useNew  = fmtI2s;
    // The word belongs to the level it was sent under: the current level for
    // I2S, the level just left behind for right-justified framing.
    strobe.isRight = fmtI2s ? (wsLevel == lrPolarity) : (wsLast == lrPolarity);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPrev <= '0;
      primed  <= 1'b0;
      locked  <= 1'b0;
      wsLast  <= 1'b0;
      bitCnt  <= '0;
    end else begin
      cfgPrev <= cfgNow;
      if (cfgChanged) begin
        primed <= 1'b0;
        locked <= 1'b0;
        bitCnt <= '0;
      end else if (bckRise) begin
        primed <= 1'b1;
        wsLast <= wsLevel;
        if (wordEdge) begin
          locked <= 1'b1;
          bitCnt <= CNT_W'(1);
        end else if (bitCnt != CNT_MAX) begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  // After a settings change the receiver is unlocked until a new edge.
  AST_UNLOCK_ON_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cfgChanged |=> !locked); // R9

endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import sarx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strobe,
  input  logic                dataBit,
  input  logic [1:0]          wordSel,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleValid,
  output logic                sampleRight
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] rawWord;
  logic [SAMPLE_W-1:0] extWord;

  // I2S completes on the arriving bit; right-justified on the bits already held.
  assign rawWord = strobe.useNew ? {shiftReg[SAMPLE_W-2:0], dataBit} : shiftReg;

  always_comb begin
    case (wordSel)
      WL_16:   extWord = {{(SAMPLE_W-LEN_SHORT){rawWord[LEN_SHORT-1]}}, rawWord[LEN_SHORT-1:0]};
      WL_20:   extWord = {{(SAMPLE_W-LEN_MID){rawWord[LEN_MID-1]}}, rawWord[LEN_MID-1:0]};
      default: extWord = rawWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      sampleData  <= '0;
      sampleValid <= 1'b0;
      sampleRight <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[SAMPLE_W-2:0], dataBit};
      sampleValid <= strobe.capture;
      if (strobe.capture) begin
        sampleData  <= extWord;
        sampleRight <= strobe.isRight;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R8

  AST_SEXT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && wordSel == WL_16) |->
      (sampleData[SAMPLE_W-1:LEN_SHORT-1] == '0 || sampleData[SAMPLE_W-1:LEN_SHORT-1] == '1)); // R6

  AST_SEXT_MID: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && wordSel == WL_20) |->
      (sampleData[SAMPLE_W-1:LEN_MID-1] == '0 || sampleData[SAMPLE_W-1:LEN_MID-1] == '1)); // R2

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serData,
  input  logic                fmtI2s,
  input  logic [1:0]          wordSel,
  input  logic                lrPolarity,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleValid,
  output logic                sampleRight
);

  localparam int CNT_W = $clog2(SAMPLE_W) + 2;

  logic      bckRise;
  logic      wsLevel;
  logic      dataBit;
  rxStrobe_t strobe;

  sarx_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .bitClk  (bitClk),
    .wordClk (wordClk),
    .serData (serData),
    .bckRise (bckRise),
    .wsLevel (wsLevel),
    .dataBit (dataBit)
  );

  sarx_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .bckRise    (bckRise),
    .wsLevel    (wsLevel),
    .fmtI2s     (fmtI2s),
    .wordSel    (wordSel),
    .lrPolarity (lrPolarity),
    .strobe     (strobe)
  );

  sarx_datapath data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dataBit     (dataBit),
    .wordSel     (wordSel),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .sampleRight (sampleRight)
  );

  // Samples only ever follow a detected bit clock rise by one register.
  AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> $past(bckRise)); // R1

  // A settings change suppresses delivery in the following cycle.
  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({fmtI2s, lrPolarity, wordSel}) |=> !sampleValid); // R9

endmodule

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        wordClk = 1'b0;
  logic        serData = 1'b0;
  logic        fmtI2s = 1'b0;
  logic [1:0]  wordSel = 2'b00;
  logic        lrPolarity = 1'b0;
  logic [23:0] sampleData;
  logic        sampleValid;
  logic        sampleRight;

  int testsRun = 0;
  int testsFailed = 0;
  int unsigned cyc = 0;
  int unsigned riseCycle = 0;
  logic prevValid = 1'b0;
  logic [24:0] expQ[$];
  string dataTag = "R3";

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) cyc <= cyc + 1;

  serial_audio_rx dut_i (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk), .serData(serData),
    .fmtI2s(fmtI2s), .wordSel(wordSel), .lrPolarity(lrPolarity),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleRight(sampleRight)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [1:0] sel);
    if (sel == 2'b00) return 16;
    if (sel == 2'b01) return 20;
    return 24;
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] v, input int n);
    logic [23:0] mask;
    logic [23:0] r;
    mask = (24'h1 << n) - 24'h1;
    r = v & mask;
    if (v[n-1]) r = r | ~mask;
    return r;
  endfunction

  // Monitor: every strobe is compared against the next expected sample.
  always @(negedge clk) begin
    if (sampleValid) begin
      if (prevValid) check("R8 strobe width", 32'd1, 32'd0);
      if (expQ.size() == 0) begin
        check("R9 unexpected sample", {8'h0, sampleData}, 32'hDEAD);
      end else begin
        logic [24:0] e;
        e = expQ.pop_front();
        check(dataTag, {8'h0, sampleData}, {8'h0, e[23:0]});       // R3 R4 R6
        check("R5 channel tag", {31'h0, sampleRight}, {31'h0, e[24]});
        check("R1 latency", cyc - riseCycle, 32'd3);
      end
    end
    prevValid = sampleValid;
  end

  task automatic sendBit(input logic ws, input logic d);
    @(negedge clk);
    bitClk = 1'b0; wordClk = ws; serData = d;
    repeat (4) @(negedge clk);
    bitClk = 1'b1; riseCycle = cyc;
    repeat (3) @(negedge clk);
  endtask

  // One half-frame of 'slot' bit clocks carrying an N-bit word.
  task automatic sendHalf(input int slot, input logic ws, input logic [23:0] val,
                          input logic expectIt, input logic isRight);
    int n;
    n = lenOf(wordSel);
    if (expectIt) expQ.push_back({isRight, sext(val, n)});
    for (int b = 0; b < slot; b++) begin
      logic d;
      d = 1'($urandom);
      if (!fmtI2s) begin
        if (b >= slot - n) d = val[n - 1 - (b - (slot - n))];
      end else begin
        if (b >= 1 && b <= n) d = val[n - b];
      end
      sendBit(ws, d);
    end
  endtask

  task automatic startRun(input logic f, input logic [1:0] sel, input logic pol);
    @(negedge clk);
    rstN = 1'b0; bitClk = 1'b0;
    fmtI2s = f; wordSel = sel; lrPolarity = pol;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    dataTag = f ? "R4 data" : "R3 data";
    repeat (2) @(negedge clk);
    sendHalf(32, pol, 24'h0, 1'b0, 1'b0);   // right-level preamble, not expected
  endtask

  task automatic sendFrame(input int slot, input logic [23:0] l, input logic [23:0] r);
    sendHalf(slot, ~lrPolarity, l, 1'b1, 1'b0);
    sendHalf(slot, lrPolarity, r, 1'b1, 1'b1);
  endtask

  task automatic endRun();
    sendHalf(2, ~lrPolarity, 24'h0, 1'b0, 1'b0);  // flush: too short to complete a word
    repeat (10) @(negedge clk);
    check("R8 all samples delivered", expQ.size(), 32'd0);
    expQ.delete();
  endtask

  initial begin
    void'($urandom(32'd715));
    // R10: reset state
    repeat (4) @(negedge clk);
    check("R10 valid at reset", {31'h0, sampleValid}, 32'd0);
    check("R10 data at reset", {8'h0, sampleData}, 32'd0);
    check("R10 tag at reset", {31'h0, sampleRight}, 32'd0);

    // Directed corners: both framings (R7), every length code incl. reserved (R2).
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 4; s++) begin
        int n;
        logic [23:0] maxPos;
        logic [23:0] minNeg;
        n = lenOf(2'(s));
        maxPos = (24'h1 << (n - 1)) - 24'h1;
        minNeg = 24'h1 << (n - 1);
        startRun(1'(f), 2'(s), 1'(s));
        sendFrame(32, maxPos, minNeg);       // R6 extremes
        sendFrame(n + f, 24'hFFFFFF, 24'h0); // minimal slot length
        endRun();
      end
    end

    // R9: a settings change drops the partial frame and waits for new edges.
    startRun(1'b0, 2'b00, 1'b0);
    sendHalf(32, 1'b1, 24'h1234, 1'b0, 1'b0);
    @(negedge clk);
    lrPolarity = 1'b1;
    repeat (3) @(negedge clk);
    sendHalf(32, 1'b1, 24'h5555, 1'b0, 1'b0);
    sendHalf(32, 1'b0, 24'h8001, 1'b1, 1'b0);  // low is left under polarity 1 (R5)
    sendHalf(2, 1'b1, 24'h0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check("R9 only post-change sample", expQ.size(), 32'd0);
    expQ.delete();

    // Random runs: mixed framing, length, polarity and slot padding.
    for (int run = 0; run < 12; run++) begin
      logic f;
      logic [1:0] sel;
      int slot;
      f = 1'($urandom);
      sel = 2'($urandom % 3);
      startRun(f, sel, 1'($urandom));
      slot = ($urandom % 2) ? 32 : lenOf(sel) + int'(f);
      for (int k = 0; k < 3; k++) sendFrame(slot, 24'($urandom), 24'($urandom));
      endRun();
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected<190000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule